// File: doc/BRIEF.md
# Cache Diagnostic Access Port

This block turns alternate-space load and store requests into direct accesses to the tag and data arrays of an instruction cache and a data cache. A request carries an address, an 8-bit space code, a write flag and write data. For the four diagnostic space codes the block drives a single set of array strobes that go to the external RAMs: an enable, a write enable, an array select, the way, the line index, the sub-block index, the tag and valid write values, and the data write word. Array reads are synchronous. One cycle after a read request the block returns the formatted read word. For a tag read that word holds the address tag in the upper field and the valid bits in the low bits.

The way, line and word fields come from the cache geometry parameters. They are packed into the address from most to least significant, above two zero byte-offset bits. While a cache flush is running, no diagnostic access may reach the arrays. Any such attempt is answered one cycle later with a data exception carrying trap code 0x09. Space codes outside the diagnostic range are ignored.

Top module: `cache_diag_port`

## Requirements
- R1: Space code 0x0C selects instruction-cache tags, 0x0D instruction-cache data, 0x0E data-cache tags and 0x0F data-cache data. These appear on `arr_sel` as 0, 1, 2 and 3: bit 1 is set for the data cache and bit 0 is set for the data array.
- R2: With WB = log2(LINE_BYTES/4) and LB = log2(WAY_BYTES/LINE_BYTES), `arr_word` = addr[2+WB-1:2], `arr_line` = addr[2+WB+LB-1:2+WB] and `arr_way` is the log2(NWAYS) bits directly above the line field. Higher address bits have no effect.
- R3: A tag write drives `arr_we`=1, `tag_wr` = wdata[31:12] and `vld_wr` = wdata[LINE_BYTES/4-1:0] in the request cycle.
- R4: A data write drives `arr_we`=1 and `dat_wr` = wdata in the request cycle, and the word is stored at the sub-block that R2 selects.
- R5: One cycle after a tag read, `rsp_valid`=1 and `rsp_rdata` holds the stored tag in bits [31:12], the valid bits from bit 0 upward, and zero in every other bit.
- R6: One cycle after a data read, `rsp_valid`=1 and `rsp_rdata` equals the stored word.
- R7: A diagnostic request while `flush_active`=1 drives no array enable and changes no stored value. One cycle later it raises `trap`=1 with `trap_code`=0x09 and `rsp_valid`=0.
- R8: A request with a space code outside 0x0C..0x0F raises no array enable, no response and no trap, and stored contents are left unchanged.
- R9: Writes produce no response. Reset clears `rsp_valid` and `trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Address-space code |
| req_addr | input | 32 | Diagnostic address |
| req_wdata | input | 32 | Store data |
| flush_active | input | 1 | Cache flush in progress |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write enable |
| arr_sel | output | 2 | Array select (R1 encoding) |
| arr_way | output | WAY_W | Way number |
| arr_line | output | LINE_W | Line index |
| arr_word | output | WORD_W | Sub-block index |
| tag_wr | output | 20 | Tag write value |
| vld_wr | output | VLD_W | Valid bits write value |
| dat_wr | output | 32 | Data write value |
| rd_tag | input | 20 | Tag read from RAM (one cycle after enable) |
| rd_vld | input | VLD_W | Valid bits read from RAM |
| rd_data | input | 32 | Data word read from RAM |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response word |
| trap | output | 1 | Data exception |
| trap_code | output | 8 | Trap code (0x09 on flush conflict) |

## Verification
The bench builds the block with 512-byte ways, 32-byte lines and two ways. This gives a single way bit, a 4-bit line field and a 3-bit sub-block field with eight valid bits. The address layout is then small enough that field misplacement by a single bit lands on a different model entry. The geometry also lets the bench sweep every sub-block of a line and both ways while junk is placed in the high address bits. The eight valid bits exercise the full valid field next to the zero gap below bit 12.

// File: rtl/cdiag_pkg.sv
package cdiag_pkg;

    localparam int          TAG_LSB    = 12;
    localparam int          TAG_W      = 32 - TAG_LSB;
    localparam logic [5:0]  DIAG_SPACE = 6'h03;   // codes 0x0C..0x0F
    localparam logic [7:0]  TRAP_FLUSH = 8'h09;

    typedef enum logic [1:0] {
        SEL_ITAG  = 2'd0,
        SEL_IDATA = 2'd1,
        SEL_DTAG  = 2'd2,
        SEL_DDATA = 2'd3
    } arr_sel_e;

    typedef struct packed {
        logic     hit;     // space code is diagnostic
        logic     write;
        arr_sel_e sel;
    } diag_cmd_t;

    function automatic logic is_diag_space(input logic [7:0] code);
        return code[7:2] == DIAG_SPACE;
    endfunction

    function automatic logic is_tag_array(input arr_sel_e s);
        return s == SEL_ITAG || s == SEL_DTAG;
    endfunction

endpackage

// File: rtl/cdiag_decode.sv
module cdiag_decode
    import cdiag_pkg::*;
#(
    parameter int WAY_W  = 2,
    parameter int LINE_W = 7,
    parameter int WORD_W = 3
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_asi,
    input  logic [31:0]       req_addr,
    output diag_cmd_t         cmd,
    output logic [WAY_W-1:0]  way,
    output logic [LINE_W-1:0] line,
    output logic [WORD_W-1:0] word
);
    localparam int WORD_LSB = 2;
    localparam int LINE_LSB = WORD_LSB + WORD_W;
    localparam int WAY_LSB  = LINE_LSB + LINE_W;

    always_comb begin
        cmd.hit   = req_valid && is_diag_space(req_asi);
        cmd.write = req_write;
        cmd.sel   = arr_sel_e'(req_asi[1:0]);
        word      = req_addr[WORD_LSB +: WORD_W];
        line      = req_addr[LINE_LSB +: LINE_W];
        way       = req_addr[WAY_LSB  +: WAY_W];
    end

    always_comb begin
        if (req_valid && !is_diag_space(req_asi))
            p_foreign_space_r8: assert (!cmd.hit);
    end
endmodule

// File: rtl/cdiag_resp.sv
module cdiag_resp
    import cdiag_pkg::*;
#(
    parameter int VLD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  diag_cmd_t        cmd,
    input  logic             flush_active,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [VLD_W-1:0] rd_vld,
    input  logic [31:0]      rd_data,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             trap,
    output logic [7:0]       trap_code
);
    localparam int GAP_W = TAG_LSB - VLD_W;

    logic was_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            trap      <= 1'b0;
            was_tag   <= 1'b0;
        end else begin
            rsp_valid <= cmd.hit && !cmd.write && !flush_active;
            trap      <= cmd.hit && flush_active;
            was_tag   <= is_tag_array(cmd.sel);
        end
    end

    always_comb begin
        trap_code = trap ? TRAP_FLUSH : 8'h00;
        if (!rsp_valid)
            rsp_rdata = '0;
        else if (was_tag)
            rsp_rdata = {rd_tag, {GAP_W{1'b0}}, rd_vld};
        else
            rsp_rdata = rd_data;
    end

    p_trap_excl_r7: assert property (@(posedge clk) disable iff (rst)
        trap |-> !rsp_valid);
    p_flush_trap_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && flush_active) |=> (trap && trap_code == TRAP_FLUSH));
    p_write_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.write) |=> !rsp_valid);
endmodule

// File: rtl/cache_diag_port.sv
module cache_diag_port
    import cdiag_pkg::*;
#(
    parameter int WAY_BYTES  = 4096,
    parameter int LINE_BYTES = 32,
    parameter int NWAYS      = 4,
    localparam int VLD_W  = LINE_BYTES / 4,
    localparam int WORD_W = $clog2(VLD_W),
    localparam int LINE_W = $clog2(WAY_BYTES / LINE_BYTES),
    localparam int WAY_W  = $clog2(NWAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_asi,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              flush_active,
    output logic              arr_en,
    output logic              arr_we,
    output logic [1:0]        arr_sel,
    output logic [WAY_W-1:0]  arr_way,
    output logic [LINE_W-1:0] arr_line,
    output logic [WORD_W-1:0] arr_word,
    output logic [19:0]       tag_wr,
    output logic [VLD_W-1:0]  vld_wr,
    output logic [31:0]       dat_wr,
    input  logic [19:0]       rd_tag,
    input  logic [VLD_W-1:0]  rd_vld,
    input  logic [31:0]       rd_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              trap,
    output logic [7:0]        trap_code
);
    initial begin
        if (VLD_W > TAG_LSB || NWAYS < 2 || WAY_BYTES < 2 * LINE_BYTES)
            $error("cache_diag_port: unsupported geometry");
    end

    diag_cmd_t cmd;

    cdiag_decode #(.WAY_W(WAY_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_asi   (req_asi),
        .req_addr  (req_addr),
        .cmd       (cmd),
        .way       (arr_way),
        .line      (arr_line),
        .word      (arr_word)
    );

    always_comb begin
        arr_en  = cmd.hit && !flush_active;
        arr_we  = arr_en && cmd.write;
        arr_sel = cmd.sel;
        tag_wr  = req_wdata[31:TAG_LSB];
        vld_wr  = req_wdata[VLD_W-1:0];
        dat_wr  = req_wdata;
    end

    cdiag_resp #(.VLD_W(VLD_W)) u_rsp (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .flush_active (flush_active),
        .rd_tag       (rd_tag),
        .rd_vld       (rd_vld),
        .rd_data      (rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .trap         (trap),
        .trap_code    (trap_code)
    );

    p_no_en_flush_r7: assert property (@(posedge clk) disable iff (rst)
        flush_active |-> !arr_en);
    p_read_answers_r5: assert property (@(posedge clk) disable iff (rst)
        (arr_en && !arr_we) |=> rsp_valid);
    p_sel_map_r1: assert property (@(posedge clk) disable iff (rst)
        (arr_en && req_asi == 8'h0E) |-> arr_sel == 2'd2);
    p_tag_fields_r3: assert property (@(posedge clk) disable iff (rst)
        (arr_we && !arr_sel[0]) |-> (tag_wr == req_wdata[31:12] && vld_wr == req_wdata[VLD_W-1:0]));
endmodule

// File: tb/sim_cache_diag_port.sv
`timescale 1ns/1ps
module sim_cache_diag_port;
    localparam int WAYB = 512, LINEB = 32, NW = 2;
    localparam int VW = LINEB / 4, WDW = 3, LNW = 4, WYW = 1;
    localparam int NLINE = 16, NWORD = 8;

    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic req_valid = 0, req_write = 0, flush_active = 0;
    logic [7:0] req_asi = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic arr_en, arr_we, rsp_valid, trap;
    logic [1:0] arr_sel;
    logic [WYW-1:0] arr_way;
    logic [LNW-1:0] arr_line;
    logic [WDW-1:0] arr_word;
    logic [19:0] tag_wr, rd_tag = 0;
    logic [VW-1:0] vld_wr, rd_vld = 0;
    logic [31:0] dat_wr, rd_data = 0, rsp_rdata;
    logic [7:0] trap_code;

    cache_diag_port #(.WAY_BYTES(WAYB), .LINE_BYTES(LINEB), .NWAYS(NW)) u0 (.*);

    // RAMs driven by the design's strobes
    logic [19:0] ram_tag [int];
    logic [VW-1:0] ram_vld [int];
    logic [31:0] ram_dat [int];
    always @(posedge clk) begin
        if (arr_en) begin
            int tk, dk;
            tk = (arr_sel[1] * NW + int'(arr_way)) * NLINE + int'(arr_line);
            dk = tk * NWORD + int'(arr_word);
            if (!arr_sel[0]) begin
                if (arr_we) begin ram_tag[tk] = tag_wr; ram_vld[tk] = vld_wr; end
                else begin
                    rd_tag <= ram_tag.exists(tk) ? ram_tag[tk] : 20'h0;
                    rd_vld <= ram_vld.exists(tk) ? ram_vld[tk] : '0;
                end
            end else begin
                if (arr_we) ram_dat[dk] = dat_wr;
                else rd_data <= ram_dat.exists(dk) ? ram_dat[dk] : 32'h0;
            end
        end
    end

    // Reference model state
    logic [31:0] ref_tagword [int];
    logic [31:0] ref_dat [int];
    int checks = 0, fails = 0;
    bit exp_rv = 0, exp_tr = 0;
    logic [31:0] exp_rd = 0;
    string exp_req = "R9";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_rsp();
        chk(exp_tr ? "R7" : exp_req, {31'b0, rsp_valid}, {31'b0, exp_rv});
        chk(exp_tr ? "R7" : "R8", {31'b0, trap}, {31'b0, exp_tr});
        if (exp_tr) chk("R7", {24'b0, trap_code}, 32'h09);
        if (exp_rv) chk(exp_req, rsp_rdata, exp_rd);
    endtask

    task automatic apply(bit v, bit w, logic [7:0] asi, logic [31:0] a, logic [31:0] d, bit fl);
        int way, line, word, key;
        bit hit, cache, isdata;
        @(negedge clk);
        check_rsp();
        req_valid = v; req_write = w; req_asi = asi; req_addr = a; req_wdata = d; flush_active = fl;
        #1;
        hit = v && asi >= 8'h0C && asi <= 8'h0F;
        cache = asi[1]; isdata = asi[0];
        word = (a >> 2) % NWORD; line = (a >> 5) % NLINE; way = (a >> 9) % NW;
        key = (int'(cache) * NW + way) * NLINE + line;
        chk(fl ? "R7" : (hit ? "R1" : "R8"), {31'b0, arr_en}, {31'b0, hit && !fl});
        if (hit && !fl) begin
            chk("R1", {30'b0, arr_sel}, {30'b0, cache, isdata});
            chk("R2", {31'b0, arr_way}, way);
            chk("R2", {28'b0, arr_line}, line);
            chk("R2", {29'b0, arr_word}, word);
            chk(isdata ? "R4" : "R3", {31'b0, arr_we}, {31'b0, w});
            if (w && !isdata) begin
                chk("R3", {12'b0, tag_wr}, {12'b0, d[31:12]});
                chk("R3", {24'b0, vld_wr}, {24'b0, d[7:0]});
            end
            if (w && isdata) chk("R4", dat_wr, d);
        end
        exp_rv = hit && !fl && !w;
        exp_tr = hit && fl;
        exp_req = isdata ? "R6" : "R5";
        if (hit && !fl) begin
            if (!isdata) begin
                if (w) ref_tagword[key] = {d[31:12], 4'b0, d[7:0]};
                else exp_rd = ref_tagword.exists(key) ? ref_tagword[key] : 32'h0;
            end else begin
                if (w) ref_dat[key * NWORD + word] = d;
                else exp_rd = ref_dat.exists(key * NWORD + word) ? ref_dat[key * NWORD + word] : 32'h0;
            end
        end
        if (!hit) exp_req = "R8";
        if (w) exp_req = "R9";
    endtask

    function automatic logic [31:0] mk(int way, int line, int word, logic [31:0] junk);
        return (junk & 32'hFFFF_FC00) | (way << 9) | (line << 5) | (word << 2);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", {30'b0, rsp_valid, trap}, 32'h0);
        rst = 0;
        // tag writes/reads in both caches, both ways
        for (int c = 0; c < 2; c++)
            for (int wy = 0; wy < NW; wy++)
                for (int ln = 0; ln < NLINE; ln += 5) begin
                    apply(1, 1, 8'h0C + 8'(2 * c), mk(wy, ln, 0, 32'h5A5A_0000),
                          32'hF0F0_1000 ^ (c << 31) ^ (wy << 20) ^ (ln << 14) ^ 32'hFFF ^ (ln * 3), 0);
                end
        for (int c = 0; c < 2; c++)
            for (int wy = 0; wy < NW; wy++)
                for (int ln = 0; ln < NLINE; ln += 5)
                    apply(1, 0, 8'h0C + 8'(2 * c), mk(wy, ln, 3, 32'hC300_0000), 32'h0, 0);
        // data writes to every sub-block, then reads
        for (int c = 0; c < 2; c++)
            for (int wy = 0; wy < NW; wy++)
                for (int wd = 0; wd < NWORD; wd++)
                    apply(1, 1, 8'h0D + 8'(2 * c), mk(wy, 7, wd, 32'hFFFF_0000),
                          32'h1357_0000 + (c << 12) + (wy << 8) + wd, 0);
        for (int c = 0; c < 2; c++)
            for (int wy = 0; wy < NW; wy++)
                for (int wd = NWORD - 1; wd >= 0; wd--)
                    apply(1, 0, 8'h0D + 8'(2 * c), mk(wy, 7, wd, 32'h0), 32'h0, 0);
        // writes and reads during flush: trap, no change
        apply(1, 1, 8'h0F, mk(1, 7, 2, 0), 32'hDEAD_BEEF, 1);
        apply(1, 1, 8'h0E, mk(0, 5, 0, 0), 32'hDEAD_BEEF, 1);
        apply(1, 0, 8'h0D, mk(0, 7, 2, 0), 32'h0, 1);
        apply(1, 0, 8'h0F, mk(1, 7, 2, 0), 32'h0, 0);
        apply(1, 0, 8'h0E, mk(0, 5, 0, 0), 32'h0, 0);
        // foreign space codes: ignored, storage untouched
        apply(1, 1, 8'h0B, mk(1, 7, 4, 0), 32'hBAD0_0001, 0);
        apply(1, 1, 8'h10, mk(0, 10, 0, 0), 32'hBAD0_0002, 0);
        apply(1, 0, 8'h2C, mk(1, 7, 4, 0), 32'h0, 0);
        apply(1, 0, 8'h0F, mk(1, 7, 4, 0), 32'h0, 0);
        apply(1, 0, 8'h0C, mk(0, 10, 0, 0), 32'h0, 0);
        // idle flush cycle, no request
        apply(0, 0, 8'h0C, 32'h0, 32'h0, 1);
        apply(0, 0, 8'h00, 32'h0, 32'h0, 0);
        apply(0, 0, 8'h00, 32'h0, 32'h0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule